// File: doc/BRIEF.md
# Masked-write PHY control register bank

This block holds the control word set that steers a camera-side physical-layer receiver: which lanes are enabled, which are forced into receive or stop states, the serial test port pins (clear, clock, enable, data-in), and a handful of path-selection bits. Software reaches it over a plain memory-mapped bus with a write strobe, an address and a 32-bit data word. Reads are combinational from the address.

Every write is self-masking. The upper half of the data word is a per-bit enable for the lower half: a lower bit changes only when its partner sixteen positions up is 1. A driver therefore sets one field, for example the lane-enable nibble, by placing the value at the field's shift and a run of ones at shift plus sixteen, without reading the register first and without disturbing neighbouring fields.

One extra address returns a read-only status word whose low byte is the test-data-out value returned by the PHY's test interface.

Top module: `phy_ctl_bank`

## Requirements
- R1: After reset every control output and every control register readback is zero.
- R2: A write to a control register sets stored bit k (0 to 15) to wdata[k] when wdata[k+16] is 1 and leaves it unchanged when wdata[k+16] is 0.
- R3: A write whose upper half is all zero leaves the addressed register unchanged.
- R4: The lane register sits at offset 0x00: lane_off is bits [3:0], force_rx bits [7:4], force_stop bits [11:8], lane_en bits [15:12].
- R5: The test register sits at offset 0x04: tst_clr is bit 0, tst_clk bit 1, tst_en bit 2, tst_din bits [10:3]; bits [15:11] are stored and readable only.
- R6: The path register sits at offset 0x08: path_sel is bit 0, src_sel bit 1, base_dir bit 2, turn_req bits [5:3]; bits [15:6] are stored and readable only.
- R7: A read of a control register returns its sixteen stored bits in [15:0] and zero in [31:16].
- R8: A read of offset 0x0C returns tst_dout in bits [7:0] and zero above; writes to 0x0C change no register.
- R9: A write to any other offset changes no register, and a read of any other offset returns zero.
- R10: A write to one control register leaves the other control registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] new bits |
| bus_rdata | output | 32 | Read word for bus_addr |
| tst_dout | input | 8 | Test-data-out value from the PHY |
| lane_off | output | 4 | Per-lane turnaround disable |
| force_rx | output | 4 | Per-lane force receive mode |
| force_stop | output | 4 | Per-lane force stop state |
| lane_en | output | 4 | Per-lane enable |
| tst_clr | output | 1 | Test port clear |
| tst_clk | output | 1 | Test port clock |
| tst_en | output | 1 | Test port enable (address phase) |
| tst_din | output | 8 | Test port data in |
| path_sel | output | 1 | Receive path selection |
| src_sel | output | 1 | Secondary receiver source selection |
| base_dir | output | 1 | Lane base direction |
| turn_req | output | 3 | Turnaround request bits |

## Verification
On every cycle the assertions check that masked-off bits of the written register hold while enabled bits take the new data, that idle cycles and writes to unmapped or status offsets disturb no control field, that the upper read half is always zero and that the status offset mirrors tst_dout. Field placement on the output ports, isolation between the three control registers, the reset state, and the read value of every unmapped offset are shown by the bench's sweeps, which drive hundreds of pseudo-random mask and data words and walk the whole address space.

// File: rtl/phy_ctl_bank.sv
module phy_ctl_bank #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        tst_dout,
  output logic [3:0]        lane_off,
  output logic [3:0]        force_rx,
  output logic [3:0]        force_stop,
  output logic [3:0]        lane_en,
  output logic              tst_clr,
  output logic              tst_clk,
  output logic              tst_en,
  output logic [7:0]        tst_din,
  output logic              path_sel,
  output logic              src_sel,
  output logic              base_dir,
  output logic [2:0]        turn_req
);
  localparam int NCTL = 3;
  localparam int HALF = 16;
  localparam int STRIDE = 4;
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(NCTL * STRIDE);

  logic [HALF-1:0] ctl_q [NCTL];
  logic [HALF-1:0] wmask, wbits;

  assign wmask = bus_wdata[2*HALF-1:HALF];
  assign wbits = bus_wdata[HALF-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTL; i++) ctl_q[i] <= '0;
    end else if (bus_wr) begin
      for (int i = 0; i < NCTL; i++)
        if (bus_addr == ADDR_W'(i * STRIDE))
          ctl_q[i] <= (ctl_q[i] & ~wmask) | (wbits & wmask);
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCTL; i++)
      if (bus_addr == ADDR_W'(i * STRIDE)) bus_rdata = {{HALF{1'b0}}, ctl_q[i]};
    if (bus_addr == STAT_OFF) bus_rdata = {24'b0, tst_dout};
  end

  assign lane_off   = ctl_q[0][3:0];
  assign force_rx   = ctl_q[0][7:4];
  assign force_stop = ctl_q[0][11:8];
  assign lane_en    = ctl_q[0][15:12];

  assign tst_clr = ctl_q[1][0];
  assign tst_clk = ctl_q[1][1];
  assign tst_en  = ctl_q[1][2];
  assign tst_din = ctl_q[1][10:3];

  assign path_sel = ctl_q[2][0];
  assign src_sel  = ctl_q[2][1];
  assign base_dir = ctl_q[2][2];
  assign turn_req = ctl_q[2][5:3];
endmodule

module phy_ctl_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [7:0]        tst_dout,
  input logic [15:0]       lane_w,
  input logic [10:0]       test_w,
  input logic [5:0]        path_w
);
  logic unmapped;
  assign unmapped = !(bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(8));

  // R2: masked-off bits of the lane register hold
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=>
      ((lane_w & ~$past(bus_wdata[31:16])) == ($past(lane_w) & ~$past(bus_wdata[31:16]))));

  // R2: enabled bits of the lane register take the new data
  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=>
      ((lane_w & $past(bus_wdata[31:16])) == ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

  // R3: idle cycles change nothing
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(lane_w) && $stable(test_w) && $stable(path_w)));

  // R7: upper read half always zero
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0);

  // R8: status offset mirrors the test output
  assert_status_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(12)) |-> (bus_rdata == {24'b0, tst_dout}));

  // R8, R9: status or unmapped writes disturb no field
  assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> ($stable(lane_w) && $stable(test_w) && $stable(path_w)));

  // R9: unmapped reads are zero
  assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped && bus_addr != ADDR_W'(12)) |-> (bus_rdata == 32'h0));
endmodule

bind phy_ctl_bank phy_ctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tst_dout(tst_dout),
  .lane_w({lane_en, force_stop, force_rx, lane_off}),
  .test_w({tst_din, tst_en, tst_clk, tst_clr}),
  .path_w({turn_req, base_dir, src_sel, path_sel})
);

// File: tb/tb_phy_ctl_bank.sv
`timescale 1ns/1ps
module tb_phy_ctl_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  tst_dout = 0;
  logic [3:0]  lane_off, force_rx, force_stop, lane_en;
  logic        tst_clr, tst_clk, tst_en, path_sel, src_sel, base_dir;
  logic [7:0]  tst_din;
  logic [2:0]  turn_req;

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] sh [3];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  phy_ctl_bank dut (.*);

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #2;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ports_chk(input string tag);
    chk({tag, " R4 lane_off"},   32'(lane_off),   32'(sh[0][3:0]));
    chk({tag, " R4 force_rx"},   32'(force_rx),   32'(sh[0][7:4]));
    chk({tag, " R4 force_stop"}, 32'(force_stop), 32'(sh[0][11:8]));
    chk({tag, " R4 lane_en"},    32'(lane_en),    32'(sh[0][15:12]));
    chk({tag, " R5 test pins"},  32'({tst_din, tst_en, tst_clk, tst_clr}), 32'(sh[1][10:0]));
    chk({tag, " R6 path pins"},  32'({turn_req, base_dir, src_sel, path_sel}), 32'(sh[2][5:0]));
  endtask

  task automatic all_chk(input string tag);
    ports_chk(tag);
    for (int i = 0; i < 3; i++) rd_chk({tag, " R7 readback"}, 8'(i * 4), {16'h0, sh[i]});
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual %0d expected less", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    all_chk("R1 reset");
    rst_n = 1;
    @(negedge clk);
    all_chk("R1 after release");

    // R2/R4/R5/R6/R10: pseudo-random masked writes to every control register
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [31:0] d;
      seed = nxt(seed); r = int'(seed % 3);
      seed = nxt(seed); d = seed;
      wr(8'(r * 4), d);
      sh[r] = (sh[r] & ~d[31:16]) | (d[15:0] & d[31:16]);
      all_chk("R2 R10 masked write");
    end

    // R2: walking single-bit enable sets then clears each bit of each register
    for (int r = 0; r < 3; r++)
      for (int b = 0; b < 16; b++) begin
        wr(8'(r * 4), 32'(1) << (b + 16) | 32'hFFFF);
        sh[r][b] = 1'b1;
        all_chk("R2 walk set");
        wr(8'(r * 4), 32'(1) << (b + 16));
        sh[r][b] = 1'b0;
        all_chk("R2 walk clear");
      end

    // R3: zero-mask writes with nonzero data
    for (int r = 0; r < 3; r++) begin
      wr(8'(r * 4), 32'hFFFF_FFFF);
      sh[r] = 16'hFFFF;
      wr(8'(r * 4), 32'h0000_0000);
      wr(8'(r * 4), 32'h0000_A5A5);
      all_chk("R3 zero mask");
    end

    // R4: field-sized write touches only one lane field
    wr(8'h00, 32'h0F00_0500);
    sh[0][11:8] = 4'h5;
    all_chk("R4 single field");

    // R8: status sweep and status write ignored
    for (int v = 0; v < 256; v++) begin
      tst_dout = 8'(v);
      rd_chk("R8 status", 8'h0C, 32'(v));
    end
    wr(8'h0C, 32'hFFFF_0000);
    all_chk("R8 status write");

    // R9: every unmapped offset ignores writes and reads zero
    for (int a = 0; a < 256; a++) begin
      if (a == 0 || a == 4 || a == 8 || a == 12) continue;
      wr(8'(a), (a % 2 == 0) ? 32'hFFFF_FFFF : 32'hFFFF_0000);
      rd_chk("R9 unmapped read", 8'(a), 32'h0);
      ports_chk("R9 unmapped write");
    end
    all_chk("R9 final");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule